// File: doc/BRIEF.md
# Transceiver Reconfiguration Sequencer

This block is a control state machine. It runs the safe order of steps for changing the settings of a serial transceiver channel, or of the PLL that drives its transmitter, while the link is live. A start pulse carries two inputs. The first is the target, which is the PLL, the transmitter only, the receiver only, or both directions. The second is a flag that is set when the change moves to another data rate or protocol mode, or switches the PRBS pattern on or off.

The sequencer first places the affected directions in digital reset. If the change flag is set, it then also places them in analog reset. Next it takes the configuration bus from the calibration engine when that engine holds it. It then gives control to an external register writer and waits for that writer to finish. When the change flag is set, it requests recalibration and waits for calibration to complete. Finally it releases the analog resets and then the digital resets.

A minimum hold time, in clock cycles, separates each reset edge from the next step. The sequencer does not wait forever: if the bus grant or the calibration engine does not answer in time, it sets an error flag and returns to idle with its resets still asserted.

Top module: `xcvr_reconf_seq`

## Requirements
- R1: One cycle after an accepted start, the digital reset of every direction in scope is asserted. At that point no analog reset and no write request is active, and busy_o is high.
- R2: The reset scope is set by target_i. 0 (PLL) and 1 (TX) select the transmitter. 2 (RX) selects the receiver. 3 (duplex) selects both. A direction outside the scope has its resets left untouched.
- R3: Analog reset is asserted only when chg_rate_i was high at start, and only after digital reset. When chg_rate_i was low, no analog reset and no recalibration request occurs.
- R4: After each reset assertion or release, the next step is taken exactly hold_i+1 cycles later. hold_i is sampled at start.
- R5: After the reset holds, if bus_cal_owned_i is high the sequencer raises bus_req_o and does not start the write until it sees bus_gnt_i. If bus_cal_owned_i is low, it starts the write with no request. bus_req_o drops when the write is acknowledged.
- R6: wr_start_o stays high until wr_ack_i is sampled high, and drops in the next cycle.
- R7: When the rate changed, recal_req_o rises right after the write ack. It holds until cal_busy_i is seen high. The sequencer then stalls until cal_busy_i goes low. The recalibration scope is: PLL target gives recal_pll_o and recal_tx_o; TX gives recal_tx_o; RX gives recal_rx_o; duplex gives recal_tx_o and recal_rx_o.
- R8: Analog resets are released first. Digital resets are released hold_i+1 cycles after that. No analog reset is ever active without the digital reset of the same direction.
- R9: done_o is a one-cycle pulse, issued hold_i+1 cycles after the digital release, in the same cycle that busy_o falls.
- R10: A start pulse while busy_o is high is ignored and changes no reset output.
- R11: If either bus_gnt_i or cal_busy_i fails to answer within TMO_CYCLES cycles, err_o is set and busy_o falls. The resets already asserted stay asserted, and bus_req_o and recal_req_o drop. The next start clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in idle |
| target_i | input | 2 | Target: 0 PLL, 1 TX, 2 RX, 3 duplex |
| chg_rate_i | input | 1 | Change crosses rate/mode or toggles PRBS |
| hold_i | input | HOLD_W | Minimum hold cycles after each reset edge |
| bus_cal_owned_i | input | 1 | Calibration engine currently owns the configuration bus |
| bus_gnt_i | input | 1 | Bus grant |
| bus_req_o | output | 1 | Bus request |
| wr_start_o | output | 1 | Start register writes (held until ack) |
| wr_ack_i | input | 1 | Register writes finished |
| cal_busy_i | input | 1 | Calibration in progress |
| recal_req_o | output | 1 | Recalibration request |
| recal_pll_o | output | 1 | Recalibrate the PLL |
| recal_tx_o | output | 1 | Recalibrate the transmitter |
| recal_rx_o | output | 1 | Recalibrate the receiver |
| tx_dig_rst_o | output | 1 | Transmitter digital reset |
| rx_dig_rst_o | output | 1 | Receiver digital reset |
| tx_ana_rst_o | output | 1 | Transmitter analog reset |
| rx_ana_rst_o | output | 1 | Receiver analog reset |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout error, held until next start |

## Verification
The assertions check several ordering rules on every cycle:
- an analog reset is never active without its digital reset;
- writes happen only under digital reset;
- a write after a bus request follows a grant;
- wr_start_o is held until acknowledged;
- a recalibration request happens only while analog reset is active;
- done_o is a one-cycle pulse that leaves every reset released;
- busy_o rises only from a start.

Other behaviours can only be shown by the bench scenarios, because they depend on a sequence of inputs:
- the exact hold_i+1 spacing between steps;
- the mapping from target to reset scope and recalibration scope;
- a start ignored while busy;
- both timeout paths, which leave their resets in place;
- recovery on the next start, which clears leftover analog resets.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  typedef enum logic [1:0] {
    TGT_PLL    = 2'd0,
    TGT_TX     = 2'd1,
    TGT_RX     = 2'd2,
    TGT_DUPLEX = 2'd3
  } tgt_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIG_ON,
    ST_ANA_ON,
    ST_BUS_CHK,
    ST_BUS_WAIT,
    ST_WRITE,
    ST_CAL_ARM,
    ST_CAL_WAIT,
    ST_ANA_OFF,
    ST_DIG_OFF
  } state_e;
endpackage

// File: rtl/xrs_scope_map.sv
module xrs_scope_map
  import xrs_pkg::*;
(
  input  tgt_e tgt_i,
  output logic rst_tx_o,
  output logic rst_rx_o,
  output logic cal_pll_o,
  output logic cal_tx_o,
  output logic cal_rx_o
);
  always_comb begin
    rst_tx_o  = 1'b0;
    rst_rx_o  = 1'b0;
    cal_pll_o = 1'b0;
    cal_tx_o  = 1'b0;
    cal_rx_o  = 1'b0;
    unique case (tgt_i)
      TGT_PLL: begin
        rst_tx_o  = 1'b1;
        cal_pll_o = 1'b1;
        cal_tx_o  = 1'b1;
      end
      TGT_TX: begin
        rst_tx_o = 1'b1;
        cal_tx_o = 1'b1;
      end
      TGT_RX: begin
        rst_rx_o = 1'b1;
        cal_rx_o = 1'b1;
      end
      TGT_DUPLEX: begin
        rst_tx_o = 1'b1;
        rst_rx_o = 1'b1;
        cal_tx_o = 1'b1;
        cal_rx_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xrs_cycle_cnt.sv
// Saturating cycle counter, cleared on every state change.
module xrs_cycle_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (clr_i)        cnt_o <= '0;
    else if (cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/xcvr_reconf_seq.sv
module xcvr_reconf_seq
  import xrs_pkg::*;
#(
  parameter int unsigned HOLD_W     = 8,
  parameter int unsigned TMO_CYCLES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        target_i,
  input  logic              chg_rate_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              bus_cal_owned_i,
  input  logic              bus_gnt_i,
  output logic              bus_req_o,
  output logic              wr_start_o,
  input  logic              wr_ack_i,
  input  logic              cal_busy_i,
  output logic              recal_req_o,
  output logic              recal_pll_o,
  output logic              recal_tx_o,
  output logic              recal_rx_o,
  output logic              tx_dig_rst_o,
  output logic              rx_dig_rst_o,
  output logic              tx_ana_rst_o,
  output logic              rx_ana_rst_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned TMO_W = $clog2(TMO_CYCLES + 1);
  localparam int unsigned CNT_W = (HOLD_W > TMO_W) ? HOLD_W : TMO_W;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYCLES - 1);

  state_e state_q, state_d;
  tgt_e   tgt_q, tgt_d, map_tgt;
  logic   rate_q, rate_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic   tx_dig_q, tx_dig_d, rx_dig_q, rx_dig_d;
  logic   tx_ana_q, tx_ana_d, rx_ana_q, rx_ana_d;
  logic   bus_req_q, bus_req_d, wr_q, wr_d, recal_q, recal_d;
  logic   done_q, done_d, err_q, err_d;
  logic [CNT_W-1:0] cnt;
  logic   hold_done, tmo_hit;
  logic   m_rst_tx, m_rst_rx, m_cal_pll, m_cal_tx, m_cal_rx;

  assign map_tgt = (state_q == ST_IDLE) ? tgt_e'(target_i) : tgt_q;

  xrs_scope_map u_map (
    .tgt_i    (map_tgt),
    .rst_tx_o (m_rst_tx),
    .rst_rx_o (m_rst_rx),
    .cal_pll_o(m_cal_pll),
    .cal_tx_o (m_cal_tx),
    .cal_rx_o (m_cal_rx)
  );

  xrs_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_d != state_q),
    .cnt_o (cnt)
  );

  assign hold_done = (cnt >= CNT_W'(hold_q));
  assign tmo_hit   = (cnt == TMO_LAST);

  always_comb begin
    state_d  = state_q;
    tgt_d    = tgt_q;
    rate_d   = rate_q;
    hold_d   = hold_q;
    tx_dig_d = tx_dig_q;
    rx_dig_d = rx_dig_q;
    tx_ana_d = tx_ana_q;
    rx_ana_d = rx_ana_q;
    bus_req_d = bus_req_q;
    wr_d     = wr_q;
    recal_d  = recal_q;
    err_d    = err_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        tgt_d    = tgt_e'(target_i);
        rate_d   = chg_rate_i;
        hold_d   = hold_i;
        tx_dig_d = tx_dig_q | m_rst_tx;
        rx_dig_d = rx_dig_q | m_rst_rx;
        err_d    = 1'b0;
        state_d  = ST_DIG_ON;
      end
      ST_DIG_ON: if (hold_done) begin
        if (rate_q) begin
          tx_ana_d = tx_ana_q | m_rst_tx;
          rx_ana_d = rx_ana_q | m_rst_rx;
          state_d  = ST_ANA_ON;
        end else begin
          state_d  = ST_BUS_CHK;
        end
      end
      ST_ANA_ON: if (hold_done) state_d = ST_BUS_CHK;
      ST_BUS_CHK: begin
        if (bus_cal_owned_i) begin
          bus_req_d = 1'b1;
          state_d   = ST_BUS_WAIT;
        end else begin
          wr_d    = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_BUS_WAIT: begin
        if (bus_gnt_i) begin
          wr_d    = 1'b1;
          state_d = ST_WRITE;
        end else if (tmo_hit) begin
          bus_req_d = 1'b0;
          err_d     = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_WRITE: if (wr_ack_i) begin
        wr_d      = 1'b0;
        bus_req_d = 1'b0;
        if (rate_q) begin
          recal_d = 1'b1;
          state_d = ST_CAL_ARM;
        end else if (tx_ana_q || rx_ana_q) begin
          // analog reset left over from an aborted run
          tx_ana_d = 1'b0;
          rx_ana_d = 1'b0;
          state_d  = ST_ANA_OFF;
        end else begin
          tx_dig_d = 1'b0;
          rx_dig_d = 1'b0;
          state_d  = ST_DIG_OFF;
        end
      end
      ST_CAL_ARM: begin
        if (cal_busy_i) begin
          recal_d = 1'b0;
          state_d = ST_CAL_WAIT;
        end else if (tmo_hit) begin
          recal_d = 1'b0;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_CAL_WAIT: begin
        if (!cal_busy_i) begin
          tx_ana_d = 1'b0;
          rx_ana_d = 1'b0;
          state_d  = ST_ANA_OFF;
        end else if (tmo_hit) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_ANA_OFF: if (hold_done) begin
        tx_dig_d = 1'b0;
        rx_dig_d = 1'b0;
        state_d  = ST_DIG_OFF;
      end
      ST_DIG_OFF: if (hold_done) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tgt_q     <= TGT_PLL;
      rate_q    <= 1'b0;
      hold_q    <= '0;
      tx_dig_q  <= 1'b0;
      rx_dig_q  <= 1'b0;
      tx_ana_q  <= 1'b0;
      rx_ana_q  <= 1'b0;
      bus_req_q <= 1'b0;
      wr_q      <= 1'b0;
      recal_q   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      tgt_q     <= tgt_d;
      rate_q    <= rate_d;
      hold_q    <= hold_d;
      tx_dig_q  <= tx_dig_d;
      rx_dig_q  <= rx_dig_d;
      tx_ana_q  <= tx_ana_d;
      rx_ana_q  <= rx_ana_d;
      bus_req_q <= bus_req_d;
      wr_q      <= wr_d;
      recal_q   <= recal_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  assign tx_dig_rst_o = tx_dig_q;
  assign rx_dig_rst_o = rx_dig_q;
  assign tx_ana_rst_o = tx_ana_q;
  assign rx_ana_rst_o = rx_ana_q;
  assign bus_req_o    = bus_req_q;
  assign wr_start_o   = wr_q;
  assign recal_req_o  = recal_q;
  assign recal_pll_o  = recal_q & m_cal_pll;
  assign recal_tx_o   = recal_q & m_cal_tx;
  assign recal_rx_o   = recal_q & m_cal_rx;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic bus_gnt_i,
  input logic bus_req_o,
  input logic wr_start_o,
  input logic wr_ack_i,
  input logic recal_req_o,
  input logic tx_dig_rst_o,
  input logic rx_dig_rst_o,
  input logic tx_ana_rst_o,
  input logic rx_ana_rst_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  assert_tx_ana_in_dig_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ana_rst_o |-> tx_dig_rst_o);
  assert_rx_ana_in_dig_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ana_rst_o |-> rx_dig_rst_o);
  assert_write_under_rst_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> (tx_dig_rst_o || rx_dig_rst_o));
  assert_write_after_gnt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_start_o) && bus_req_o) |-> $past(bus_gnt_i));
  assert_write_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_start_o && !wr_ack_i) |=> wr_start_o);
  assert_recal_in_ana_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recal_req_o |-> ((tx_ana_rst_o || rx_ana_rst_o) && !wr_start_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(tx_dig_rst_o || rx_dig_rst_o || tx_ana_rst_o || rx_ana_rst_o || busy_o));
  assert_err_keeps_rst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ((tx_dig_rst_o || rx_dig_rst_o) && !busy_o && !recal_req_o));
  assert_busy_from_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);
endmodule

bind xcvr_reconf_seq xrs_checker u_xrs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .bus_gnt_i   (bus_gnt_i),
  .bus_req_o   (bus_req_o),
  .wr_start_o  (wr_start_o),
  .wr_ack_i    (wr_ack_i),
  .recal_req_o (recal_req_o),
  .tx_dig_rst_o(tx_dig_rst_o),
  .rx_dig_rst_o(rx_dig_rst_o),
  .tx_ana_rst_o(tx_ana_rst_o),
  .rx_ana_rst_o(rx_ana_rst_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/xcvr_reconf_seq_test.sv
`timescale 1ns/1ps
module xcvr_reconf_seq_test;
  localparam int unsigned HOLD_W = 8;
  localparam int unsigned TMO    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] target = 2'd0;
  logic chg_rate = 1'b0;
  logic [HOLD_W-1:0] hold = '0;
  logic bus_owned = 1'b0, bus_gnt = 1'b0, wr_ack = 1'b0, cal_busy = 1'b0;
  logic bus_req, wr_start, recal_req, recal_pll, recal_tx, recal_rx;
  logic tx_dig, rx_dig, tx_ana, rx_ana, busy, done, err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  xcvr_reconf_seq #(.HOLD_W(HOLD_W), .TMO_CYCLES(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_i(target),
    .chg_rate_i(chg_rate), .hold_i(hold), .bus_cal_owned_i(bus_owned),
    .bus_gnt_i(bus_gnt), .bus_req_o(bus_req), .wr_start_o(wr_start),
    .wr_ack_i(wr_ack), .cal_busy_i(cal_busy), .recal_req_o(recal_req),
    .recal_pll_o(recal_pll), .recal_tx_o(recal_tx), .recal_rx_o(recal_rx),
    .tx_dig_rst_o(tx_dig), .rx_dig_rst_o(rx_dig), .tx_ana_rst_o(tx_ana),
    .rx_ana_rst_o(rx_ana), .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [1:0] t, input logic r, input int h);
    target = t; chg_rate = r; hold = HOLD_W'(h); start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_wr(output int n);
    n = 0;
    while (!wr_start && n < 60) begin tick(); n++; end
  endtask

  task automatic ack_write();
    wr_ack = 1'b1; tick(); wr_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk({tx_dig, rx_dig, tx_ana, rx_ana} == 4'b0, "R1 reset state rst", {tx_dig, rx_dig, tx_ana, rx_ana}, 0);
    chk({bus_req, wr_start, recal_req, busy, done, err} == 6'b0, "R9 reset state ctl",
        {bus_req, wr_start, recal_req, busy, done, err}, 0);
  endtask

  task automatic t_duplex_rate();
    int n;
    bus_owned = 1'b0;
    kick(2'd3, 1'b1, 3);
    chk(tx_dig && rx_dig, "R2 duplex dig", {tx_dig, rx_dig}, 3);
    chk(!tx_ana && !rx_ana && !wr_start && busy, "R1 dig first", {tx_ana, rx_ana, wr_start, busy}, 1);
    n = 0;
    while (!tx_ana && n < 50) begin tick(); n++; end
    chk(n == 4, "R4 dig->ana spacing", n, 4);
    chk(tx_ana && rx_ana, "R3 ana asserted on rate change", {tx_ana, rx_ana}, 3);
    wait_wr(n);
    chk(n == 5, "R4 ana hold then bus check", n, 5);
    chk(!bus_req, "R5 no request when bus free", bus_req, 0);
    repeat (3) tick();
    chk(wr_start, "R6 write held w/o ack", wr_start, 1);
    ack_write();
    chk(!wr_start, "R6 write drops after ack", wr_start, 0);
    chk(recal_req, "R7 recal requested", recal_req, 1);
    chk({recal_pll, recal_tx, recal_rx} == 3'b011, "R7 duplex recal scope", {recal_pll, recal_tx, recal_rx}, 3);
    repeat (2) tick();
    chk(recal_req, "R7 recal held until busy", recal_req, 1);
    cal_busy = 1'b1; tick();
    chk(!recal_req, "R7 recal drops on busy", recal_req, 0);
    repeat (3) tick();
    chk(tx_ana && rx_ana && busy, "R7 stall while busy", {tx_ana, rx_ana, busy}, 7);
    cal_busy = 1'b0; tick();
    chk(!tx_ana && !rx_ana && tx_dig && rx_dig, "R8 ana released first",
        {tx_ana, rx_ana, tx_dig, rx_dig}, 3);
    n = 0;
    while (tx_dig && n < 50) begin tick(); n++; end
    chk(n == 4 && !rx_dig, "R8 dig release spacing", n, 4);
    n = 0;
    while (!done && n < 50) begin tick(); n++; end
    chk(n == 4 && !busy, "R9 done after hold", n, 4);
    tick();
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  task automatic t_tx_norate();
    int n, bad;
    bus_owned = 1'b1;
    kick(2'd1, 1'b0, 0);
    chk(tx_dig && !rx_dig, "R2 tx scope", {tx_dig, rx_dig}, 2);
    n = 0; bad = 0;
    while (!bus_req && n < 20) begin tick(); n++; if (tx_ana || rx_ana) bad++; end
    chk(bus_req, "R5 request when cal owns bus", bus_req, 1);
    repeat (4) begin tick(); if (wr_start) bad++; end
    chk(!wr_start, "R5 no write before grant", wr_start, 0);
    bus_gnt = 1'b1; tick(); bus_gnt = 1'b0;
    chk(wr_start, "R5 write after grant", wr_start, 1);
    ack_write();
    chk(!recal_req && !bus_req, "R3 no recal, R5 request dropped", {recal_req, bus_req}, 0);
    n = 0;
    while (!done && n < 30) begin tick(); n++; if (tx_ana || rx_ana || recal_req) bad++; end
    chk(bad == 0, "R3 no analog reset without rate change", bad, 0);
    chk(done && !tx_dig, "R9 done no-rate run", {done, tx_dig}, 2);
    bus_owned = 1'b0;
  endtask

  task automatic t_pll_ignore();
    int n, rxhits, dones;
    kick(2'd0, 1'b1, 1);
    chk(tx_dig && !rx_dig, "R2 pll scope tx only", {tx_dig, rx_dig}, 2);
    kick(2'd2, 1'b1, 1);
    chk(!rx_dig, "R10 start ignored while busy", rx_dig, 0);
    wait_wr(n);
    ack_write();
    chk({recal_pll, recal_tx, recal_rx} == 3'b110, "R7 pll recal scope", {recal_pll, recal_tx, recal_rx}, 6);
    cal_busy = 1'b1; tick(); cal_busy = 1'b0;
    n = 0; rxhits = 0; dones = 0;
    while (n < 40) begin
      tick(); n++;
      if (rx_dig || rx_ana) rxhits++;
      if (done) dones++;
    end
    chk(rxhits == 0, "R10 ignored start left rx untouched", rxhits, 0);
    chk(dones == 1 && !busy && !tx_dig, "R10 single completion", dones, 1);
  endtask

  task automatic t_cal_timeout();
    int n;
    kick(2'd2, 1'b1, 0);
    chk(rx_dig && !tx_dig, "R2 rx scope", {tx_dig, rx_dig}, 1);
    wait_wr(n);
    ack_write();
    chk(recal_rx && !recal_tx && !recal_pll, "R7 rx recal scope", {recal_pll, recal_tx, recal_rx}, 1);
    n = 0;
    while (!err && n < 60) begin tick(); n++; end
    chk(err && !busy, "R11 cal timeout error", {err, busy}, 2);
    chk(rx_dig && rx_ana && !recal_req, "R11 resets kept after cal timeout",
        {rx_dig, rx_ana, recal_req}, 6);
  endtask

  task automatic t_bus_timeout();
    int n;
    bus_owned = 1'b1;
    kick(2'd1, 1'b0, 0);
    chk(!err, "R11 start clears err", err, 0);
    n = 0;
    while (!err && n < 60) begin tick(); n++; end
    chk(err && tx_dig && !bus_req && !busy, "R11 bus timeout keeps reset",
        {err, tx_dig, bus_req, busy}, 12);
    bus_owned = 1'b0;
  endtask

  task automatic t_recover();
    int n;
    kick(2'd3, 1'b0, 0);
    wait_wr(n);
    ack_write();
    n = 0;
    while (!done && n < 30) begin tick(); n++; end
    chk(done && {tx_dig, rx_dig, tx_ana, rx_ana} == 4'b0 && !err, "R8 recovery releases all",
        {tx_dig, rx_dig, tx_ana, rx_ana}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_duplex_rate();
    t_tx_norate();
    t_pll_ignore();
    t_cal_timeout();
    t_bus_timeout();
    t_recover();
    repeat (2) tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule